// File: doc/BRIEF.md
# Codec control-word decoder with power-up and clock-loss powerdown

This block sits behind the serial control port of a voice filter/codec. It keeps two 8-bit control registers: a path register (transmit gain, receive gain, loopback and powerdown) and a drive register (six system drive outputs and a test-mode selector). A three-level address input picks where a captured control byte goes. That input is modelled as a 2-bit code: negative, ground or positive. When the address is negative, a static flag can mark the control line as held at a steady level rather than carrying words. In that case the line level alone chooses normal operation or powerdown.

The block powers up in the powerdown state and refuses writes for a fixed number of bit-clock cycles. A monitor runs on a free-running reference clock. If the bit clock sits high for longer than a set number of reference cycles, the monitor asynchronously returns the whole block to its power-up state. Downstream logic uses the outputs to set gain pads, loopback switches, analog power, the test paths and the drive pins.

Top module: `codec_mode_ctl`

## Requirements
- R1: While `rst_n` is low: `power_down`=1, `sd_out`=0, both gain codes are 0, `test_sel`=0, and both loopback flags are 0.
- R2: After reset release, the block holds the power-up state for 2 synchronizer cycles plus `HOLD_CYCLES` (25) bit-clock cycles. During this hold any strobed word is ignored, so the path register still reads powerdown (bits 7:6 = 11) afterwards.
- R3: A word strobed with `addr_code`=00 (negative) and `ctl_static`=0 loads the path register and clears the drive register to zero. Transmit gain is bits 2:0 and receive gain is bits 5:3, each a binary dB count from 0 to 7.
- R4: A word strobed with `addr_code`=01 (ground), or with the unused code 11, loads the path register and leaves the drive register unchanged.
- R5: A word strobed with `addr_code`=10 (positive) loads the drive register and leaves the path register unchanged. `pcm_inhibit` is 1 whenever the address is positive. `sd_out[i]` equals drive-register bit i, and 1 means active.
- R6: Path register bits 7:6 decode as follows: 00 is normal, 01 sets `dig_loop`, 10 sets `ana_loop`, and 11 sets `power_down`. At most one of the three outputs is high.
- R7: `test_sel` copies drive-register bits 7:6 (00 none, 01 transmit filter, 10 receive filter, 11 codec). It is forced to 00 whenever the address is negative.
- R8: With the address negative, `ctl_static`=1 and `ctl_level`=0, the gain codes read 0, there is no loopback and no powerdown, and `sd_out` keeps the drive register value.
- R9: With the address negative, `ctl_static`=1 and `ctl_level`=1, `power_down` is 1. Returning to a non-static address restores the stored path register.
- R10: While the path register selects powerdown, positive-address words still update `sd_out`.
- R11: If the bit clock stays high for more than `LOSS_LIMIT` (40) reference cycles, `power_down` goes to 1 and `sd_out` goes to 0 at once. Once the clock resumes, the block repeats the power-up hold and comes back in the power-up state. A stop shorter than the limit changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; registers update on its rising edge |
| ref_clk | input | 1 | Free-running reference clock for the clock-loss monitor |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_code | input | 2 | Control address: 00 negative, 01 ground, 10 positive, 11 as ground |
| ctl_static | input | 1 | 1 when the control line is held at a steady level |
| ctl_level | input | 1 | Steady level of the control line |
| ctl_strobe | input | 1 | One-cycle pulse: `ctl_word` holds a complete byte |
| ctl_word | input | 8 | Captured control byte, bit 7 first on the wire |
| tx_gain | output | 3 | Transmit gain, +0 to +7 dB |
| rx_gain | output | 3 | Receive attenuation, 0 to 7 dB |
| dig_loop | output | 1 | Digital loopback active |
| ana_loop | output | 1 | Analog loopback active |
| power_down | output | 1 | Analog sections and PCM output disabled |
| sd_out | output | 6 | System drive outputs, 1 = active |
| test_sel | output | 2 | Selected test configuration |
| pcm_inhibit | output | 1 | PCM transfer blocked for this address |

## Verification
A drive-register write can land in the same cycle in which the path register holds powerdown. The bench provokes this by first loading 11 into path bits 7:6 and then strobing a positive-address word. It then requires `sd_out` to follow the new byte while `power_down` stays high. A clock stop also coincides with live drive outputs. The bench stops the clock on purpose, once shorter and once longer than the limit, and judges by whether `sd_out` keeps its value or drops to zero.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;

  typedef enum logic [1:0] {
    ADDR_NEG = 2'b00,
    ADDR_GND = 2'b01,
    ADDR_POS = 2'b10,
    ADDR_RSV = 2'b11
  } addr_e;

  typedef enum logic [1:0] {
    PATH_NORMAL = 2'b00,
    PATH_DLOOP  = 2'b01,
    PATH_ALOOP  = 2'b10,
    PATH_OFF    = 2'b11
  } path_e;

  typedef enum logic [1:0] {
    TEST_NONE  = 2'b00,
    TEST_TXF   = 2'b01,
    TEST_RXF   = 2'b10,
    TEST_CODEC = 2'b11
  } test_e;

  typedef struct packed {
    logic load_a;
    logic load_b;
    logic clear_b;
  } wr_cmd_t;

  function automatic wr_cmd_t decode_write(addr_e addr, logic strobe,
                                           logic busy, logic is_static);
    wr_cmd_t c;
    c = '0;
    if (strobe && !busy) begin
      unique case (addr)
        ADDR_NEG: begin
          c.load_a  = !is_static;
          c.clear_b = !is_static;
        end
        ADDR_POS: c.load_b = 1'b1;
        default:  c.load_a = 1'b1;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/codec_rst_sync.sv
module codec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/codec_clk_loss.sv
module codec_clk_loss #(
  parameter int LOSS_LIMIT = 40,
  parameter int STAGES     = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic lost
);
  localparam int CW = $clog2(LOSS_LIMIT + 1);

  logic [STAGES-1:0] lvl_q, lvl_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              lost_q, lost_d;
  logic              cnt_en;

  always_comb begin
    lvl_d  = {lvl_q[STAGES-2:0], mon_clk};
    cnt_en = lvl_q[STAGES-1] && (cnt_q != CW'(LOSS_LIMIT));
    if (!lvl_q[STAGES-1]) cnt_d = '0;
    else if (cnt_en)      cnt_d = cnt_q + 1'b1;
    else                  cnt_d = cnt_q;
    lost_d = lvl_q[STAGES-1] && (cnt_q == CW'(LOSS_LIMIT));
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign lost = lost_q;
endmodule

// File: rtl/codec_pwrup_hold.sv
module codec_pwrup_hold #(
  parameter int HOLD_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != CW'(HOLD_CYCLES));
    cnt_d  = cnt_en ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = cnt_en;
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_ctrl_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  addr_e             addr,
  input  logic              is_static,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] reg_a,
  output logic [WORD_W-1:0] reg_b
);
  localparam logic [WORD_W-1:0] A_INIT = {2'b11, {(WORD_W-2){1'b0}}};

  wr_cmd_t           cmd;
  logic [WORD_W-1:0] a_q, a_d, b_q, b_d;
  logic              a_en, b_en;

  always_comb begin
    cmd  = decode_write(addr, strobe, busy, is_static);
    a_en = cmd.load_a;
    b_en = cmd.load_b | cmd.clear_b;
    a_d  = word;
    b_d  = cmd.clear_b ? '0 : word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= A_INIT;
      b_q <= '0;
    end else begin
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
    end
  end

  assign reg_a = a_q;
  assign reg_b = b_q;
endmodule

// File: rtl/codec_mode_ctl.sv
module codec_mode_ctl
  import codec_ctrl_pkg::*;
#(
  parameter int GAIN_W      = 3,
  parameter int SD_COUNT    = 6,
  parameter int HOLD_CYCLES = 25,
  parameter int LOSS_LIMIT  = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 ref_clk,
  input  logic                 rst_n,
  input  logic [1:0]           addr_code,
  input  logic                 ctl_static,
  input  logic                 ctl_level,
  input  logic                 ctl_strobe,
  input  logic [2*GAIN_W+1:0]  ctl_word,
  output logic [GAIN_W-1:0]    tx_gain,
  output logic [GAIN_W-1:0]    rx_gain,
  output logic                 dig_loop,
  output logic                 ana_loop,
  output logic                 power_down,
  output logic [SD_COUNT-1:0]  sd_out,
  output logic [1:0]           test_sel,
  output logic                 pcm_inhibit
);
  localparam int WORD_W = 2*GAIN_W + 2;

  addr_e             addr;
  logic              loss_flag;
  logic              core_arst_n;
  logic              core_rst_n;
  logic              hold_busy;
  logic [WORD_W-1:0] reg_a, reg_b;
  logic              is_neg, static_on;
  path_e             path;
  logic              force_off;

  assign addr        = addr_e'(addr_code);
  assign core_arst_n = rst_n & ~loss_flag;

  codec_clk_loss #(.LOSS_LIMIT(LOSS_LIMIT), .STAGES(SYNC_STAGES)) u_loss (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .mon_clk (clk),
    .lost    (loss_flag)
  );

  codec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (core_arst_n),
    .srst_n (core_rst_n)
  );

  codec_pwrup_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst_n (core_rst_n),
    .busy  (hold_busy)
  );

  codec_ctrl_regs #(.WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .busy      (hold_busy),
    .addr      (addr),
    .is_static (ctl_static),
    .strobe    (ctl_strobe),
    .word      (ctl_word),
    .reg_a     (reg_a),
    .reg_b     (reg_b)
  );

  always_comb begin
    is_neg    = (addr == ADDR_NEG);
    static_on = is_neg & ctl_static;
    path      = static_on ? PATH_NORMAL : path_e'(reg_a[WORD_W-1 -: 2]);
    force_off = loss_flag | hold_busy | (static_on & ctl_level) | (path == PATH_OFF);

    if (static_on || loss_flag) begin
      tx_gain = '0;
      rx_gain = '0;
    end else begin
      tx_gain = reg_a[GAIN_W-1:0];
      rx_gain = reg_a[2*GAIN_W-1:GAIN_W];
    end

    power_down  = force_off;
    dig_loop    = !force_off && (path == PATH_DLOOP);
    ana_loop    = !force_off && (path == PATH_ALOOP);
    sd_out      = loss_flag ? '0 : reg_b[SD_COUNT-1:0];
    test_sel    = (is_neg || loss_flag || hold_busy) ? TEST_NONE : reg_b[WORD_W-1 -: 2];
    pcm_inhibit = (addr == ADDR_POS);
  end
endmodule

// File: rtl/codec_mode_ctl_chk.sv
module codec_mode_ctl_chk #(
  parameter int WORD_W   = 8,
  parameter int SD_COUNT = 6
) (
  input logic                clk,
  input logic                ref_clk,
  input logic                rst_n,
  input logic                core_rst_n,
  input logic                hold_busy,
  input logic                loss_flag,
  input logic [1:0]          addr_code,
  input logic                ctl_static,
  input logic                ctl_strobe,
  input logic [WORD_W-1:0]   reg_a,
  input logic [WORD_W-1:0]   reg_b,
  input logic                dig_loop,
  input logic                ana_loop,
  input logic                power_down,
  input logic [SD_COUNT-1:0] sd_out,
  input logic [1:0]          test_sel
);
  AST_HOLD_FORCES_OFF: assert property (@(posedge clk) disable iff (!core_rst_n)
    hold_busy |-> (power_down && sd_out == '0)); // R2

  AST_NEG_WORD_CLEARS_B: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr_code == 2'b00 && ctl_strobe && !ctl_static && !hold_busy) |=> (reg_b == '0)); // R3

  AST_GND_WORD_KEEPS_B: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr_code == 2'b01 && ctl_strobe && !hold_busy) |=> $stable(reg_b)); // R4

  AST_POS_WORD_KEEPS_A: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr_code == 2'b10 && ctl_strobe && !hold_busy) |=> $stable(reg_a)); // R5

  AST_PATH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!core_rst_n)
    $countones({dig_loop, ana_loop, power_down}) <= 1); // R6

  AST_TEST_MASKED_NEG: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr_code == 2'b00) |-> (test_sel == 2'b00)); // R7

  AST_LOSS_POWERS_DOWN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    loss_flag |-> (power_down && sd_out == '0)); // R11
endmodule

bind codec_mode_ctl codec_mode_ctl_chk #(.WORD_W(WORD_W), .SD_COUNT(SD_COUNT)) u_chk (
  .clk        (clk),
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .hold_busy  (hold_busy),
  .loss_flag  (loss_flag),
  .addr_code  (addr_code),
  .ctl_static (ctl_static),
  .ctl_strobe (ctl_strobe),
  .reg_a      (reg_a),
  .reg_b      (reg_b),
  .dig_loop   (dig_loop),
  .ana_loop   (ana_loop),
  .power_down (power_down),
  .sd_out     (sd_out),
  .test_sel   (test_sel)
);

// File: tb/sim_codec_mode_ctl.sv
module sim_codec_mode_ctl;
  logic       clk, ref_clk, rst_n, clk_run;
  logic [1:0] addr_code;
  logic       ctl_static, ctl_level, ctl_strobe;
  logic [7:0] ctl_word;
  logic [2:0] tx_gain, rx_gain;
  logic       dig_loop, ana_loop, power_down, pcm_inhibit;
  logic [5:0] sd_out;
  logic [1:0] test_sel;

  int n_chk  = 0;
  int n_fail = 0;

  codec_mode_ctl u0 (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .addr_code(addr_code),
    .ctl_static(ctl_static), .ctl_level(ctl_level), .ctl_strobe(ctl_strobe),
    .ctl_word(ctl_word), .tx_gain(tx_gain), .rx_gain(rx_gain),
    .dig_loop(dig_loop), .ana_loop(ana_loop), .power_down(power_down),
    .sd_out(sd_out), .test_sel(test_sel), .pcm_inhibit(pcm_inhibit)
  );

  initial begin
    clk = 1'b0;
    forever begin
      #10;
      if (clk_run) clk = ~clk;
      else         clk = 1'b1;
    end
  end

  initial begin
    ref_clk = 1'b0;
    forever #7 ref_clk = ~ref_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] a, input logic [7:0] w);
    @(negedge clk);
    addr_code  = a;
    ctl_static = 1'b0;
    ctl_word   = w;
    ctl_strobe = 1'b1;
    @(negedge clk);
    ctl_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    clk_run = 1'b1; rst_n = 1'b0;
    addr_code = 2'b01; ctl_static = 1'b0; ctl_level = 1'b0;
    ctl_strobe = 1'b0; ctl_word = '0;
    idle(3);
    // R1 reset state
    chk("R1 power_down", power_down, 1);
    chk("R1 sd_out", sd_out, 0);
    chk("R1 gains", {tx_gain, rx_gain}, 0);
    chk("R1 test_sel", test_sel, 0);
    chk("R1 loops", {dig_loop, ana_loop}, 0);
    rst_n = 1'b1;

    // R2 write during hold is ignored
    idle(5);
    send(2'b01, 8'h00);
    chk("R2 busy power_down", power_down, 1);
    idle(40);
    chk("R2 ignored write", power_down, 1);

    // R3: negative-address words load A and clear B
    send(2'b10, 8'h3F);
    chk("R5 preload sd", sd_out, 63);
    for (int g = 0; g < 64; g++) begin
      send(2'b00, 8'(g));
      chk("R3 tx_gain", tx_gain, g % 8);
      chk("R3 rx_gain", rx_gain, g / 8);
      chk("R3 sd cleared", sd_out, 0);
      chk("R3 power_down", power_down, 0);
    end

    // R5: positive-address words load B, keep A
    for (int s = 0; s < 64; s++) begin
      send(2'b10, 8'(s));
      chk("R5 sd_out", sd_out, s);
      chk("R5 pcm_inhibit", pcm_inhibit, 1);
      chk("R5 gains kept", {tx_gain, rx_gain}, 63);
    end

    // R4: ground and unused code load A, keep B
    send(2'b01, 8'h15);
    chk("R4 tx_gain", tx_gain, 5);
    chk("R4 rx_gain", rx_gain, 2);
    chk("R4 sd kept", sd_out, 63);
    chk("R4 pcm_inhibit", pcm_inhibit, 0);
    send(2'b11, 8'h0E);
    chk("R4 code11 tx", tx_gain, 6);
    chk("R4 code11 sd kept", sd_out, 63);

    // R6 path decode
    send(2'b01, 8'h40);
    chk("R6 digital", {dig_loop, ana_loop, power_down}, 4);
    send(2'b01, 8'h80);
    chk("R6 analog", {dig_loop, ana_loop, power_down}, 2);
    send(2'b01, 8'hC0);
    chk("R6 off", {dig_loop, ana_loop, power_down}, 1);

    // R10: drive write while path register powers down
    send(2'b10, 8'h2A);
    chk("R10 sd updates", sd_out, 42);
    chk("R10 still off", power_down, 1);

    // R7 test select and its mask
    send(2'b01, 8'h00);
    for (int t = 0; t < 4; t++) begin
      send(2'b10, 8'(t << 6));
      addr_code = 2'b01;
      @(negedge clk);
      chk("R7 test_sel", test_sel, t);
      addr_code = 2'b00;
      @(negedge clk);
      chk("R7 masked", test_sel, 0);
    end

    // R8 static low
    send(2'b01, 8'h3F);
    send(2'b10, 8'h05);
    addr_code = 2'b00; ctl_static = 1'b1; ctl_level = 1'b0;
    @(negedge clk);
    chk("R8 gains zero", {tx_gain, rx_gain}, 0);
    chk("R8 not off", {dig_loop, ana_loop, power_down}, 0);
    chk("R8 sd kept", sd_out, 5);
    chk("R8 test masked", test_sel, 0);

    // R9 static high, then restore
    ctl_level = 1'b1;
    @(negedge clk);
    chk("R9 power_down", power_down, 1);
    ctl_static = 1'b0; ctl_level = 1'b0; addr_code = 2'b01;
    @(negedge clk);
    chk("R9 restored off", power_down, 0);
    chk("R9 restored tx", tx_gain, 7);

    // R11 short stop below the limit
    clk_run = 1'b0;
    #140;
    chk("R11 short stop off", power_down, 0);
    chk("R11 short stop sd", sd_out, 5);
    clk_run = 1'b1;
    idle(4);
    chk("R11 short stop after", sd_out, 5);

    // R11 long stop
    clk_run = 1'b0;
    #1000;
    chk("R11 lost off", power_down, 1);
    chk("R11 lost sd", sd_out, 0);
    clk_run = 1'b1;
    idle(40);
    chk("R11 reinit off", power_down, 1);
    chk("R11 reinit sd", sd_out, 0);
    chk("R11 reinit gains", {tx_gain, rx_gain}, 0);
    send(2'b01, 8'h00);
    chk("R11 writable again", power_down, 0);

    finish_run();
  end
endmodule